// File: doc/BRIEF.md
# OTP Program Memory Security Gate

This block stands between an external programming and readout port and an on-chip one-time-programmable store. The store has three parts: the program array, a one-byte option register, and an eight-byte user identification area. The port issues one request per cycle. It chooses a target, gives an address, and for writes gives a data byte. The block acknowledges each request on the next cycle and returns read data in that same cycle. Executing software has no path into the option register. Only this port can reach it.

One option bit is the security lock. While the lock is set, every read of the program array or the user area returns 0xFF, and the port can no longer write to any target. The option register can still be read. Programming follows one-time-programmable rules: a write can only change bits from 1 to 0. A separate erase strobe models ultraviolet erasure of a windowed part. Erase restores the program array and the user area to all ones and clears every option bit except the lock. The lock survives erase. A part erased while locked refuses all further writes.

Reset models a freshly blank part. Both arrays hold 0xFF and the option register holds 0x00.

Top module: `otp_sec_gate`

## Requirements
- R1: After reset, `ack_o` is 0, `wr_ok_o` is 0, every program byte and user byte reads 0xFF, and the option register reads 0x00.
- R2: A request sampled at a clock edge raises `ack_o` for exactly the following cycle, and read data appears on `rdata_o` in that same cycle. With no request, `ack_o` is 0.
- R3: With the lock clear, a program read (`tgt_i`=0) returns the stored byte. An accepted program write stores old AND data, so a bit can only go from 1 to 0.
- R4: With the lock set, a program read returns 0xFF at every address.
- R5: With the lock set, a write to any target is rejected (`wr_ok_o`=0) and leaves the stored byte unchanged.
- R6: The option register (`tgt_i`=1) can be read whether or not the lock is set. An accepted write replaces the whole byte. Bit 3 is the lock, and once set it cannot be cleared by a write.
- R7: The user area (`tgt_i`=2) holds 8 bytes selected by `addr_i[2:0]`. Its writes follow the same AND rule as the program array, and its reads return 0xFF while the lock is set.
- R8: An erase pulse sets every program byte and every user byte to 0xFF and clears every option bit except bit 3.
- R9: Erase never clears the lock. After an erase with the lock set, every later write is rejected.
- R10: `wr_ok_o` updates on each write request, to 1 if the write was accepted and 0 if it was rejected. Read requests leave it unchanged.
- R11: A write request in the same cycle as an erase pulse is rejected. A request to the reserved target (`tgt_i`=3) reads 0xFF and its write is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one request per cycle |
| wr_i | input | 1 | 1 for write, 0 for read |
| tgt_i | input | 2 | Target: 0 program, 1 option register, 2 user data, 3 reserved |
| addr_i | input | ADDR_W (6) | Byte address |
| wdata_i | input | 8 | Write data |
| erase_i | input | 1 | Erase pulse |
| rdata_o | output | 8 | Read data, valid when `ack_o` is 1 |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| wr_ok_o | output | 1 | Whether the most recent write was accepted |

## Verification
Some rules hold on every cycle, and the assertions check them all the time. The lock and the erased-while-locked flag never fall once set. A locked program read always returns 0xFF. Locked writes always report a rejection. The acknowledge always tracks the request. Stored bits never rise except during erase. Other behaviour depends on data across a sequence of requests, and only the bench's scenarios can show it. This includes AND-merging of successive writes and whole-byte replacement of the option register. It also includes the blank image after an unlocked erase, erase taking priority over a same-cycle write, and a held write status across reads.

// File: rtl/otp_sec_pkg.sv
package otp_sec_pkg;
  typedef enum logic [1:0] {
    TGT_PROG = 2'd0,
    TGT_CFG  = 2'd1,
    TGT_USER = 2'd2,
    TGT_RSVD = 2'd3
  } otp_tgt_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/otp_byte_store.sv
module otp_byte_store #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic             erase_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  import otp_sec_pkg::*;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (erase_i) begin
        mem_d[i] = BLANK_BYTE;
      end else if (we_i && (waddr_i == IDX_W'(i))) begin
        mem_d[i] = mem_q[i] & wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK_BYTE;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata_o = mem_q[raddr_i];

  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (mem_q[0] == BLANK_BYTE) && (mem_q[DEPTH-1] == BLANK_BYTE)); // R8
  AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> ((mem_q[0] & ~$past(mem_q[0])) == 8'h00)); // R3
endmodule

// File: rtl/otp_cfg_reg.sv
module otp_cfg_reg #(
  parameter int SEC_BIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       erase_i,
  output logic [7:0] cfg_o,
  output logic       dead_o
);
  localparam logic [7:0] SEC_MASK = 8'(1) << SEC_BIT;

  logic [7:0] cfg_q, cfg_d;
  logic       dead_q, dead_d;

  always_comb begin
    cfg_d  = cfg_q;
    dead_d = dead_q | (erase_i & cfg_q[SEC_BIT]);
    if (erase_i) begin
      cfg_d = cfg_q & SEC_MASK;
    end else if (we_i) begin
      cfg_d = wdata_i | (cfg_q & SEC_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 8'h00;
      dead_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      dead_q <= dead_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign dead_o = dead_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[SEC_BIT] |=> cfg_q[SEC_BIT]); // R9
  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |=> dead_q); // R9
endmodule

// File: rtl/otp_sec_gate.sv
module otp_sec_gate #(
  parameter int ADDR_W  = 6,
  parameter int UDATA_N = 8,
  parameter int SEC_BIT = 3,
  localparam int PROG_DEPTH = 1 << ADDR_W,
  localparam int UIDX_W = $clog2(UDATA_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [1:0]        tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              erase_i,
  output logic [7:0]        rdata_o,
  output logic              ack_o,
  output logic              wr_ok_o
);
  import otp_sec_pkg::*;

  otp_tgt_e   tgt;
  logic [7:0] cfg, prog_rd, user_rd;
  logic       dead, locked, wr_req, wr_accept;
  logic       prog_we, user_we, cfg_we;
  logic [7:0] rdata_d, rdata_q;
  logic       ack_q, wr_ok_q, wr_ok_d;

  assign tgt       = otp_tgt_e'(tgt_i);
  assign locked    = cfg[SEC_BIT];
  assign wr_req    = req_i & wr_i;
  assign wr_accept = wr_req & ~erase_i & ~locked & ~dead & (tgt != TGT_RSVD);
  assign prog_we   = wr_accept & (tgt == TGT_PROG);
  assign user_we   = wr_accept & (tgt == TGT_USER);
  assign cfg_we    = wr_accept & (tgt == TGT_CFG);

  otp_byte_store #(.DEPTH(PROG_DEPTH)) u_prog (
    .clk(clk), .rst_n(rst_n), .we_i(prog_we), .waddr_i(addr_i),
    .wdata_i(wdata_i), .erase_i(erase_i), .raddr_i(addr_i), .rdata_o(prog_rd)
  );

  otp_byte_store #(.DEPTH(UDATA_N)) u_user (
    .clk(clk), .rst_n(rst_n), .we_i(user_we), .waddr_i(addr_i[UIDX_W-1:0]),
    .wdata_i(wdata_i), .erase_i(erase_i), .raddr_i(addr_i[UIDX_W-1:0]),
    .rdata_o(user_rd)
  );

  otp_cfg_reg #(.SEC_BIT(SEC_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(wdata_i),
    .erase_i(erase_i), .cfg_o(cfg), .dead_o(dead)
  );

  always_comb begin
    unique case (tgt)
      TGT_PROG: rdata_d = locked ? BLANK_BYTE : prog_rd;
      TGT_USER: rdata_d = locked ? BLANK_BYTE : user_rd;
      TGT_CFG:  rdata_d = cfg;
      default:  rdata_d = BLANK_BYTE;
    endcase
    wr_ok_d = wr_req ? wr_accept : wr_ok_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      wr_ok_q <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      ack_q   <= req_i;
      wr_ok_q <= wr_ok_d;
      if (req_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign wr_ok_o = wr_ok_q;

  AST_LOCKED_READ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && (tgt_i == 2'd0) && locked) |=> (rdata_o == 8'hFF)); // R4
  AST_LOCKED_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wr_i && locked) |=> !wr_ok_o); // R5
  AST_ACK_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ack_o); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !ack_o); // R2
  AST_READ_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && wr_i) |=> $stable(wr_ok_o)); // R10
endmodule

// File: tb/otp_sec_gate_tb.sv
module otp_sec_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0, wr_i = 1'b0, erase_i = 1'b0;
  logic [1:0] tgt_i = 2'd0;
  logic [5:0] addr_i = 6'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       ack_o, wr_ok_o;
  int checks = 0, fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_sec_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .tgt_i(tgt_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .erase_i(erase_i),
    .rdata_o(rdata_o), .ack_o(ack_o), .wr_ok_o(wr_ok_o)
  );

  // {wr, tgt, addr, wdata, expected rdata, expected wr_ok}
  localparam int NVEC = 14;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 6'd5, 8'h3C, 8'h00, 1'b1},  // R3 program write
    {1'b0, 2'd0, 6'd5, 8'h00, 8'h3C, 1'b0},  // R3 read back
    {1'b1, 2'd0, 6'd5, 8'hF0, 8'h00, 1'b1},  // R3 second write
    {1'b0, 2'd0, 6'd5, 8'h00, 8'h30, 1'b0},  // R3 AND result
    {1'b0, 2'd0, 6'd6, 8'h00, 8'hFF, 1'b0},  // R3 untouched byte
    {1'b1, 2'd2, 6'd2, 8'hA5, 8'h00, 1'b1},  // R7 user write
    {1'b0, 2'd2, 6'd2, 8'h00, 8'hA5, 1'b0},  // R7
    {1'b1, 2'd2, 6'd2, 8'h0F, 8'h00, 1'b1},  // R7 AND
    {1'b0, 2'd2, 6'd2, 8'h00, 8'h05, 1'b0},  // R7
    {1'b1, 2'd1, 6'd0, 8'h61, 8'h00, 1'b1},  // R6 option write
    {1'b0, 2'd1, 6'd0, 8'h00, 8'h61, 1'b0},  // R6
    {1'b1, 2'd1, 6'd0, 8'h42, 8'h00, 1'b1},  // R6 replace
    {1'b0, 2'd1, 6'd0, 8'h00, 8'h42, 1'b0},  // R6
    {1'b0, 2'd3, 6'd0, 8'h00, 8'hFF, 1'b0}   // R11 reserved read
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] t, input logic [5:0] a,
                        input logic [7:0] d, input logic er);
    @(negedge clk);
    req_i = 1'b1; wr_i = w; tgt_i = t; addr_i = a; wdata_i = d; erase_i = er;
    @(negedge clk);
    req_i = 1'b0; wr_i = 1'b0; erase_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] t, input logic [5:0] a,
                    input logic [7:0] exp);
    access(1'b0, t, a, 8'h00, 1'b0);
    check(req, rdata_o, exp);
  endtask

  task automatic wr(input string req, input logic [1:0] t, input logic [5:0] a,
                    input logic [7:0] d, input logic exp_ok);
    access(1'b1, t, a, d, 1'b0);
    check(req, {7'd0, wr_ok_o}, {7'd0, exp_ok});
  endtask

  task automatic erase_pulse();
    @(negedge clk); erase_i = 1'b1;
    @(negedge clk); erase_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack", {7'd0, ack_o}, 8'h00);
    check("R1 wr_ok", {7'd0, wr_ok_o}, 8'h00);
    rd("R1 program blank", 2'd0, 6'd63, 8'hFF);
    rd("R1 user blank", 2'd2, 6'd7, 8'hFF);
    rd("R1 option blank", 2'd1, 6'd0, 8'h00);

    // R2: ack present on the response cycle, gone the cycle after
    access(1'b0, 2'd0, 6'd0, 8'h00, 1'b0);
    check("R2 ack high", {7'd0, ack_o}, 8'h01);
    @(negedge clk);
    check("R2 ack low", {7'd0, ack_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      access(v[25], v[24:23], v[22:17], v[16:9], 1'b0);
      if (v[25]) check($sformatf("vector %0d wr_ok", i), {7'd0, wr_ok_o}, {7'd0, v[0]});
      else       check($sformatf("vector %0d rdata", i), rdata_o, v[8:1]);
    end

    // R10: the last write was accepted, and reads since then keep the status at 1
    check("R10 status held", {7'd0, wr_ok_o}, 8'h01);

    // R11: a write in the same cycle as erase is rejected
    access(1'b1, 2'd0, 6'd1, 8'h00, 1'b1);
    check("R11 erase beats write", {7'd0, wr_ok_o}, 8'h00);
    // R8: blank image after an unlocked erase
    rd("R8 program 5", 2'd0, 6'd5, 8'hFF);
    rd("R8 program 1", 2'd0, 6'd1, 8'hFF);
    rd("R8 user 2", 2'd2, 6'd2, 8'hFF);
    rd("R8 option cleared", 2'd1, 6'd0, 8'h00);
    wr("R11 reserved write", 2'd3, 6'd0, 8'h00, 1'b0);
    wr("R9 unlocked erase keeps writes", 2'd0, 6'd5, 8'h12, 1'b1);
    rd("R3 after reprogram", 2'd0, 6'd5, 8'h12);

    // Set the lock, bit 3
    wr("R6 set lock", 2'd1, 6'd0, 8'h4A, 1'b1);
    rd("R6 option readable locked", 2'd1, 6'd0, 8'h4A);
    rd("R4 locked program read", 2'd0, 6'd5, 8'hFF);
    rd("R4 locked blank read", 2'd0, 6'd9, 8'hFF);
    rd("R7 locked user read", 2'd2, 6'd2, 8'hFF);
    wr("R5 locked program write", 2'd0, 6'd5, 8'h00, 1'b0);
    wr("R5 locked option write", 2'd1, 6'd0, 8'h00, 1'b0);
    rd("R5 option unchanged", 2'd1, 6'd0, 8'h4A);
    wr("R5 locked user write", 2'd2, 6'd2, 8'h00, 1'b0);

    erase_pulse();
    rd("R9 lock survives erase", 2'd1, 6'd0, 8'h08);
    rd("R9 program still blanked", 2'd0, 6'd5, 8'hFF);
    wr("R9 write after locked erase", 2'd0, 6'd0, 8'h00, 1'b0);
    wr("R9 option write after locked erase", 2'd1, 6'd0, 8'h00, 1'b0);
    rd("R9 option still locked", 2'd1, 6'd0, 8'h08);

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule